// File: doc/BRIEF.md
# Strobed Single-Bit Static Memory

This block is a 4096-word by 1-bit memory with a strobed interface, rebuilt as synchronous logic. A system clock samples an active-low select, an active-low write strobe, a 12-bit address and a data bit. Edges on the two strobes are found by comparing each sample with the one before. A cycle opens when select is first seen low. The address is captured at that point. A write strobe fall inside the cycle captures the data bit. The write is committed to the array when select is seen high again.

The data output comes with a drive flag that stands in for a tri-state pin. In a read cycle, or in a late write (which includes read-modify-write), the flag is raised and the stored bit is shown. In an early write the write strobe is already low when the cycle opens, so the flag stays low for the whole cycle. Whenever the flag is low, the data output reads 0.

Top module: `strobe_bit_ram`

## Requirements
- R1: The array holds 4096 independent bits. A bit written at one address is read back unchanged after every other address has been written.
- R2: From the first clock edge that samples select high, the drive flag and the data output are both 0, and they stay 0 while select stays high.
- R3: A clock edge that samples select low after a high sample, with the write strobe high, opens a read cycle. The address is captured at that edge, and the drive flag goes to 1 with the stored bit of that address right after that edge. Address changes later in the cycle have no effect.
- R4: In an open read cycle, the first edge that samples the write strobe low after a high sample captures the data bit at that edge. Later changes on the data input are ignored.
- R5: The captured bit is written to the captured address at the edge that samples select high again. A read cycle that opens afterwards returns the new bit.
- R6: Early write: if the write strobe is sampled low at the same edge that opens the cycle, the data bit is captured at that edge and the drive flag stays 0 for the whole cycle.
- R7: In a late write (read-modify-write), the drive flag stays 1 and the data output keeps the value read before the write, until select is sampled high.
- R8: Only the first write strobe fall in a cycle captures data. Further falls in the same cycle change neither the captured bit nor the stored result.
- R9: A write strobe fall while select is high is ignored. No location changes, and the next cycle captures a fresh address.
- R10: After the asynchronous reset, the drive flag and the data output are 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 12 | Word address |
| din_i | input | 1 | Write data bit |
| dout_o | output | 1 | Read data bit, 0 when not driven |
| dout_oe_o | output | 1 | Output drive flag |

## Verification
Each input is sampled at the rising edge. The edge that sees a strobe change also updates every result, so outputs move right after that edge: the drive flag and read bit after the edge that opens the cycle, the return to idle after the edge that sees select high, and the array contents at that same closing edge. The bench drives inputs on falling edges. A behavioural model updates on the rising edge from the same inputs. Outputs are compared with that model at every falling edge, half a period after the edge that sets them. Directed checks inside each cycle task compare the expected bit at the specific falling edges where R3, R6, R7 and R8 apply.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int unsigned ADDR_W_DEF = 12;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_EARLY = 2'd2,
    CYC_LATE  = 2'd3
  } cyc_e;
endpackage

// File: rtl/sbr_prev_reg.sv
module sbr_prev_reg #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] prev_o
);
  // strobes are idle high; reset history to idle so no edge is seen out of reset
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_o[g] <= 1'b1;
      else         prev_o[g] <= lvl_i[g];
    end
  end
endmodule

// File: rtl/sbr_bit_array.sv
module sbr_bit_array #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic              wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic              rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] mem_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

  assert_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/sbr_cycle_ctrl.sv
module sbr_cycle_ctrl
  import sbr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              wr_ni,
  input  logic              sel_prev_i,
  input  logic              wr_prev_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  input  logic              rd_bit_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic              wdata_o,
  output logic              dout_o,
  output logic              oe_o
);
  cyc_e              cyc_q;
  logic [ADDR_W-1:0] addr_q;
  logic              data_q;
  logic              wpend_q;
  logic              dout_q;
  logic              sel_fall, sel_rise, wr_fall;

  assign sel_fall = sel_prev_i & ~sel_ni;
  assign sel_rise = ~sel_prev_i & sel_ni;
  assign wr_fall  = wr_prev_i & ~wr_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= CYC_IDLE;
      addr_q  <= '0;
      data_q  <= 1'b0;
      wpend_q <= 1'b0;
      dout_q  <= 1'b0;
    end else if (sel_rise) begin
      cyc_q   <= CYC_IDLE;
      wpend_q <= 1'b0;
    end else if (sel_fall) begin
      addr_q <= addr_i;
      dout_q <= rd_bit_i;
      if (!wr_ni) begin
        cyc_q   <= CYC_EARLY;
        wpend_q <= 1'b1;
        data_q  <= din_i;
      end else begin
        cyc_q   <= CYC_READ;
        wpend_q <= 1'b0;
      end
    end else if (wr_fall && cyc_q == CYC_READ) begin
      // first write fall only: the cycle leaves READ here
      cyc_q   <= CYC_LATE;
      wpend_q <= 1'b1;
      data_q  <= din_i;
    end
  end

  assign rd_addr_o = addr_i;
  assign we_o      = sel_rise & wpend_q;
  assign waddr_o   = addr_q;
  assign wdata_o   = data_q;
  assign dout_o    = dout_q;
  assign oe_o      = (cyc_q == CYC_READ) || (cyc_q == CYC_LATE);

  assert_addr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != CYC_IDLE && !sel_fall) |=> $stable(addr_q));

  assert_early_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_fall && !wr_ni) |=> !oe_o);

  assert_rmw_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == CYC_LATE && !sel_rise) |=> (oe_o && $stable(dout_q)));

  assert_first_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fall && cyc_q == CYC_LATE && !sel_rise) |=> $stable(data_q));
endmodule

// File: rtl/strobe_bit_ram.sv
module strobe_bit_ram #(
  parameter int unsigned ADDR_W = sbr_pkg::ADDR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              dout_oe_o
);
  logic [1:0]        prev_w;
  logic [ADDR_W-1:0] rd_addr_w, waddr_w;
  logic              rd_bit_w, we_w, wdata_w, dout_w, oe_w;

  sbr_prev_reg #(.N(2)) i_prev (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({wr_ni, sel_ni}),
    .prev_o (prev_w)
  );

  sbr_cycle_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_ni     (sel_ni),
    .wr_ni      (wr_ni),
    .sel_prev_i (prev_w[0]),
    .wr_prev_i  (prev_w[1]),
    .addr_i     (addr_i),
    .din_i      (din_i),
    .rd_bit_i   (rd_bit_w),
    .rd_addr_o  (rd_addr_w),
    .we_o       (we_w),
    .waddr_o    (waddr_w),
    .wdata_o    (wdata_w),
    .dout_o     (dout_w),
    .oe_o       (oe_w)
  );

  sbr_bit_array #(.ADDR_W(ADDR_W)) i_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_w),
    .waddr_i (waddr_w),
    .wdata_i (wdata_w),
    .raddr_i (rd_addr_w),
    .rdata_o (rd_bit_w)
  );

  assign dout_oe_o = oe_w;
  assign dout_o    = oe_w & dout_w;

  assert_idle_hiz_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |=> (!dout_oe_o && !dout_o));
endmodule

// File: tb/test_strobe_bit_ram.sv
module test_strobe_bit_ram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int NWORD = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sel_ni = 1'b1;
  logic          wr_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic          din_i = 1'b0;
  logic          dout_o, dout_oe_o;

  int    n_chk = 0;
  int    n_err = 0;
  string tag_s = "R10";
  bit    cmp_en = 1'b0;

  // behavioural reference
  bit          m_mem [NWORD];
  bit          m_sel_p, m_wr_p, m_in, m_pend, m_data, m_oe, m_dout;
  int unsigned m_addr;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  strobe_bit_ram #(.ADDR_W(AW)) i_strobe_bit_ram (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_ni(sel_ni), .wr_ni(wr_ni),
    .addr_i(addr_i), .din_i(din_i), .dout_o(dout_o), .dout_oe_o(dout_oe_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sel_p = 1; m_wr_p = 1; m_in = 0; m_pend = 0;
      m_data = 0; m_oe = 0; m_dout = 0; m_addr = 0;
    end else begin
      if (!m_sel_p && sel_ni) begin
        if (m_pend) m_mem[m_addr] = m_data;
        m_in = 0; m_pend = 0; m_oe = 0; m_dout = 0;
      end else if (m_sel_p && !sel_ni) begin
        m_in = 1; m_addr = int'(addr_i);
        if (!wr_ni) begin
          m_pend = 1; m_data = din_i; m_oe = 0; m_dout = 0;
        end else begin
          m_pend = 0; m_oe = 1; m_dout = m_mem[m_addr];
        end
      end else if (m_wr_p && !wr_ni && m_in && !m_pend) begin
        m_pend = 1; m_data = din_i;
      end
      m_sel_p = sel_ni; m_wr_p = wr_ni;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock compare against the model
  always @(negedge clk_i) begin
    if (cmp_en && rst_ni) begin
      check(dout_oe_o === m_oe, {tag_s, " oe"}, int'(dout_oe_o), int'(m_oe));
      if (m_oe) check(dout_o === m_dout, {tag_s, " dout"}, int'(dout_o), int'(m_dout));
      else      check(dout_o === 1'b0, "R2 dout idle", int'(dout_o), 0);
    end
  end

  function automatic bit pat(input int a);
    return bit'(a[0] ^ a[5] ^ a[11] ^ a[3]);
  endfunction

  task automatic rd_cycle(input int a, input bit exp, input string tag);
    sel_ni = 0; wr_ni = 1; addr_i = AW'(a);
    @(negedge clk_i);
    addr_i = ~AW'(a);                       // R3: ignored
    @(negedge clk_i);
    check(dout_oe_o === 1'b1, {tag, " R3 oe"}, int'(dout_oe_o), 1);
    check(dout_o === exp, {tag, " R3 data"}, int'(dout_o), int'(exp));
    sel_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic early_wr(input int a, input bit d, input bit chk);
    sel_ni = 0; wr_ni = 0; addr_i = AW'(a); din_i = d;
    @(negedge clk_i);
    din_i = ~d; addr_i = ~AW'(a);
    if (chk) check(dout_oe_o === 1'b0, "R6 early oe", int'(dout_oe_o), 0);
    @(negedge clk_i);
    if (chk) check(dout_oe_o === 1'b0, "R6 early oe late", int'(dout_oe_o), 0);
    sel_ni = 1; wr_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic late_wr(input int a, input bit d, input bit old, input bit dbl);
    sel_ni = 0; wr_ni = 1; addr_i = AW'(a);
    @(negedge clk_i);
    check(dout_oe_o === 1'b1 && dout_o === old, "R7 pre-write read", int'(dout_o), int'(old));
    wr_ni = 0; din_i = d;
    @(negedge clk_i);
    din_i = ~d; addr_i = ~AW'(a);           // R4: ignored after capture
    check(dout_oe_o === 1'b1 && dout_o === old, "R7 hold after fall", int'(dout_o), int'(old));
    if (dbl) begin
      wr_ni = 1;
      @(negedge clk_i);
      wr_ni = 0;                            // R8: second fall, din is ~d
      @(negedge clk_i);
      check(dout_o === old, "R8 hold", int'(dout_o), int'(old));
    end
    sel_ni = 1; wr_ni = 1;
    @(negedge clk_i);
    check(dout_oe_o === 1'b0, "R2 idle after close", int'(dout_oe_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(dout_oe_o === 1'b0 && dout_o === 1'b0, "R10 in reset", int'(dout_oe_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    check(dout_oe_o === 1'b0 && dout_o === 1'b0, "R10 after reset", int'(dout_o), 0);
    cmp_en = 1;

    tag_s = "R1 fill";
    for (int a = 0; a < NWORD; a++) early_wr(a, pat(a), a < 4);
    tag_s = "R1 readback";
    for (int a = 0; a < NWORD; a++) rd_cycle(a, pat(a), "R1");

    tag_s = "R4 late";
    late_wr(5, ~pat(5), pat(5), 0);
    rd_cycle(5, ~pat(5), "R5 late commit");
    rd_cycle(6, pat(6), "R4 neighbour");

    tag_s = "R8 double";
    late_wr(9, ~pat(9), pat(9), 1);
    rd_cycle(9, ~pat(9), "R8");

    tag_s = "R6 early";
    early_wr(5, pat(5), 1);
    rd_cycle(5, pat(5), "R5 early commit");

    tag_s = "R9 stray";
    din_i = pat(9);
    wr_ni = 0; @(negedge clk_i);
    wr_ni = 1; @(negedge clk_i);
    check(dout_oe_o === 1'b0, "R9 idle", int'(dout_oe_o), 0);
    rd_cycle(9, ~pat(9), "R9 unchanged");
    rd_cycle(10, pat(10), "R9 fresh addr");

    repeat (2) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule